// File: doc/BRIEF.md
# Link Pulse Generator and Link Integrity Monitor

This block handles link maintenance on one twisted-pair port. On the transmit side it watches transmit data transitions that are qualified by the transmit enable. It keeps the line driver active for a short hold time after the last transition. Once the line has gone idle, it sends a single positive link pulse of fixed width at a fixed period. A frame that starts while a pulse is being sent cuts that pulse short at once.

On the receive side it takes two inputs: a one-cycle strobe for each received link pulse, and a level flag that is high while valid data is being received. From these it decides whether the link is good. Link pulses must arrive inside a spacing window. A pulse that comes too early is a fault. If no accepted event arrives for a timeout period, the link is declared failed. A failed link recovers on valid data, or on two link pulses spaced inside the window.

The status output is high while the link is failed. While valid data is received on a good link, the status output toggles at a slow blink rate. All times are parameters counted in cycles of the 10 MHz block clock.

Top module: `lnk_beat_unit`

## Requirements
- R1: A cycle with `tx_en` and `tx_edge` both high is transmit activity. From the next cycle, `drv_active` is high, and it stays high for exactly HOLD_CYC cycles after the last activity cycle.
- R2: `tx_edge` pulses while `tx_en` is low have no effect. `drv_active` stays low and the link pulse schedule is not disturbed.
- R3: Idle starts at reset release or when `drv_active` falls. Counting from the start of idle, `beat_drive` goes high after BEAT_CYC cycles for PULSE_CYC cycles, and this repeats every BEAT_CYC cycles while the line stays idle.
- R4: Transmit activity during a link pulse clears `beat_drive` in the next cycle. `beat_drive` and `drv_active` are never high together.
- R5: In reset and right after reset, `drv_active`, `beat_drive` and `link_status` are all low, and the monitor is in the link-good state.
- R6: In the link-good state, an `rx_beat` that comes LT_MIN_CYC to LT_MAX_CYC cycles after the last accepted event restarts the timeout. So does any cycle with `rx_valid` high.
- R7: In the link-good state, an `rx_beat` that comes fewer than LT_MIN_CYC cycles after the last accepted event moves the monitor to link-fail. `link_status` is then high from the next cycle.
- R8: If FAIL_CYC cycles pass after the last accepted event with no new one, the monitor goes to link-fail. A late `rx_beat` (more than LT_MAX_CYC cycles) is not accepted.
- R9: In link-fail, one cycle of `rx_valid` returns the monitor to link-good. Two `rx_beat` strobes spaced inside the window also return it to link-good. A single `rx_beat` alone does not.
- R10: While `rx_valid` stays high on a good link, `link_status` is low for the first BLINK_CYC cycles and then toggles every BLINK_CYC cycles. It is low again one cycle after `rx_valid` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (10 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| tx_edge | input | 1 | One-cycle strobe for each transmit data transition |
| rx_beat | input | 1 | One-cycle strobe for each received link pulse |
| rx_valid | input | 1 | High while valid receive data is present |
| beat_drive | output | 1 | Drives a positive link pulse onto the line |
| drv_active | output | 1 | Line driver held active for frame data |
| link_status | output | 1 | High on link-fail; blinks while valid data is received |

## Verification
The hardest case to reach is a frame that starts while a link pulse is being sent. Pulses come from a free-running idle counter, so the bench uses its model to predict the exact cycle the pulse starts, waits for it, and then starts the frame. Recovery from link-fail is also hard to reach: it needs a failed link, then a single beat that must not recover it, then a second beat inside the window. The bench builds this sequence directly, and the random phase draws beat spacings that often fall on both sides of the window edges.

// File: rtl/lnk_beat_unit.sv
module lnk_beat_unit #(
  parameter int HOLD_CYC   = 3,
  parameter int PULSE_CYC  = 1,
  parameter int BEAT_CYC   = 160000,
  parameter int LT_MIN_CYC = 20000,
  parameter int LT_MAX_CYC = 500000,
  parameter int FAIL_CYC   = 1000000,
  parameter int BLINK_CYC  = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_edge,
  input  logic rx_beat,
  input  logic rx_valid,
  output logic beat_drive,
  output logic drv_active,
  output logic link_status
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam int BW = $clog2(BEAT_CYC);
  localparam int GW = $clog2(FAIL_CYC + 1);
  localparam int KW = $clog2(BLINK_CYC);
  localparam logic [HW-1:0] HOLD_V  = HW'(HOLD_CYC);
  localparam logic [PW-1:0] PULSE_V = PW'(PULSE_CYC);
  localparam logic [BW-1:0] BEAT_END = BW'(BEAT_CYC - 1);
  localparam logic [GW-1:0] G_MIN  = GW'(LT_MIN_CYC);
  localparam logic [GW-1:0] G_MAX  = GW'(LT_MAX_CYC);
  localparam logic [GW-1:0] G_FAIL = GW'(FAIL_CYC);
  localparam logic [GW-1:0] G_ONE  = GW'(1);
  localparam logic [KW-1:0] BLK_END = KW'(BLINK_CYC - 1);

  logic [HW-1:0] hold_q;
  logic [PW-1:0] pls_q;
  logic [BW-1:0] beat_q;
  logic [GW-1:0] gap_q;
  logic [KW-1:0] blk_q;
  logic          fail_q, armed_q, phase_q;

  wire tx_act   = tx_en & tx_edge;
  wire beat_due = !tx_act && !drv_active && (beat_q == BEAT_END);
  wire early    = gap_q < G_MIN;
  wire in_win   = !early && (gap_q <= G_MAX);
  wire timeout  = gap_q == G_FAIL;

  assign drv_active  = hold_q != '0;
  assign beat_drive  = pls_q != '0;
  assign link_status = fail_q | phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          hold_q <= '0;
    else if (tx_act)     hold_q <= HOLD_V;
    else if (drv_active) hold_q <= hold_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || tx_act || drv_active || beat_due) beat_q <= '0;
    else                                            beat_q <= beat_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || tx_act) pls_q <= '0;
    else if (beat_due)    pls_q <= PULSE_V;
    else if (beat_drive)  pls_q <= pls_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fail_q  <= 1'b0;
      armed_q <= 1'b0;
      gap_q   <= G_ONE;
    end else if (rx_valid) begin
      fail_q  <= 1'b0;
      armed_q <= 1'b0;
      gap_q   <= G_ONE;
    end else if (!fail_q) begin
      if (rx_beat && early) begin
        fail_q  <= 1'b1;
        armed_q <= 1'b1;
        gap_q   <= G_ONE;
      end else if (rx_beat && in_win) begin
        gap_q <= G_ONE;
      end else if (timeout) begin
        fail_q  <= 1'b1;
        armed_q <= 1'b0;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end else if (rx_beat) begin
      if (armed_q && in_win) begin
        fail_q  <= 1'b0;
        armed_q <= 1'b0;
      end else begin
        armed_q <= 1'b1;
      end
      gap_q <= G_ONE;
    end else if (!timeout) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_valid) begin
      blk_q   <= '0;
      phase_q <= 1'b0;
    end else if (blk_q == BLK_END) begin
      blk_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      blk_q <= blk_q + 1'b1;
    end
  end
endmodule

// File: rtl/lnk_beat_unit_chk.sv
module lnk_beat_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic tx_edge,
  input logic rx_valid,
  input logic beat_drive,
  input logic drv_active,
  input logic link_status,
  input logic fail_q
);
  assert_act_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_edge) |=> (drv_active && !beat_drive));

  assert_rise_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_active) |-> $past(tx_en && tx_edge));

  assert_pulse_from_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat_drive) |-> $past(!drv_active));

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat_drive && drv_active));

  assert_fail_not_on_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> !$past(rx_valid));

  assert_data_recovers_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !fail_q);

  assert_quiet_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rx_valid) && !fail_q) |-> !link_status);
endmodule

bind lnk_beat_unit lnk_beat_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_edge(tx_edge),
  .rx_valid(rx_valid), .beat_drive(beat_drive), .drv_active(drv_active),
  .link_status(link_status), .fail_q(fail_q)
);

// File: tb/lnk_beat_unit_bench.sv
module lnk_beat_unit_bench;
  localparam int HOLD = 3, PULSE = 2, BEAT = 40, TMIN = 10, TMAX = 30, TFAIL = 60, BLINK = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b0, tx_edge = 1'b0, rx_beat = 1'b0, rx_valid = 1'b0;
  logic beat_drive, drv_active, link_status;

  int total = 0, bad = 0, n = 0;
  bit done = 0;
  int m_act, m_last, m_d0;
  bit m_fail, m_armed, m_run, m_ph;
  string tag_tx = "R5", tag_rx = "R5";

  always #5 clk = ~clk;

  lnk_beat_unit #(.HOLD_CYC(HOLD), .PULSE_CYC(PULSE), .BEAT_CYC(BEAT), .LT_MIN_CYC(TMIN),
                  .LT_MAX_CYC(TMAX), .FAIL_CYC(TFAIL), .BLINK_CYC(BLINK)) u_lnk_beat_unit (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_edge(tx_edge), .rx_beat(rx_beat),
    .rx_valid(rx_valid), .beat_drive(beat_drive), .drv_active(drv_active), .link_status(link_status));

  function automatic bit exp_drv();
    return (n - m_act) < HOLD;
  endfunction

  function automatic bit exp_lp();
    int z = m_act + HOLD;
    if (exp_drv() || (n - z) < BEAT) return 1'b0;
    return ((n - z) % BEAT) < PULSE;
  endfunction

  function automatic bit exp_st();
    return m_fail | m_ph;
  endfunction

  task automatic check(input logic act, input bit exp, input string tag, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s cycle=%0d actual=%0b expected=%0b", tag, what, n, act, exp);
    end
  endtask

  task automatic model(input bit en, input bit tg, input bit bt, input bit dv);
    int s;
    if (en && tg) m_act = n;
    s = (n - m_last) > TFAIL ? TFAIL : (n - m_last);
    if (dv) begin
      m_fail = 0; m_armed = 0; m_last = n;
    end else if (!m_fail) begin
      if (bt && s < TMIN) begin m_fail = 1; m_armed = 1; m_last = n; end
      else if (bt && s <= TMAX) m_last = n;
      else if (s >= TFAIL) begin m_fail = 1; m_armed = 0; end
    end else if (bt) begin
      if (m_armed && s >= TMIN && s <= TMAX) begin m_fail = 0; m_armed = 0; end
      else m_armed = 1;
      m_last = n;
    end
    if (dv) begin
      if (!m_run) begin m_run = 1; m_d0 = n; end
      m_ph = (((n - m_d0 + 1) / BLINK) % 2) == 1;
    end else begin
      m_run = 0; m_ph = 0;
    end
  endtask

  task automatic step(input bit en, input bit tg, input bit bt, input bit dv);
    tx_en = en; tx_edge = tg; rx_beat = bt; rx_valid = dv;
    @(posedge clk);
    n++;
    model(en, tg, bt, dv);
    @(negedge clk);
    check(drv_active, exp_drv(), tag_tx, "drv_active");
    check(beat_drive, exp_lp(), tag_tx, "beat_drive");
    check(link_status, exp_st(), tag_rx, "link_status");
  endtask

  task automatic idle(input int cycles, input int spacing);
    for (int i = 0; i < cycles; i++) step(0, 0, spacing > 0 && (i % spacing) == spacing - 1, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    m_act = -HOLD; m_last = 0; m_fail = 0; m_armed = 0; m_run = 0; m_ph = 0; m_d0 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(drv_active, 1'b0, "R5", "reset drv_active");
    check(beat_drive, 1'b0, "R5", "reset beat_drive");
    check(link_status, 1'b0, "R5", "reset link_status");
    rst_n = 1'b1;

    tag_tx = "R3"; tag_rx = "R6";
    idle(100, 20);

    tag_tx = "R1";
    for (int i = 0; i < 12; i++) step(1, i % 2 == 0, i == 5, 0);
    idle(70, 25);

    tag_tx = "R2";
    for (int i = 0; i < 60; i++) step(0, 1, i % 20 == 19, 0);

    tag_tx = "R4";
    while (!exp_lp()) step(0, 0, 0, 0);
    for (int i = 0; i < 6; i++) step(1, 1, 0, 0);
    idle(20, 0);
    while (!exp_lp()) step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    step(1, 1, 0, 0);
    idle(10, 0);

    tag_tx = "R3"; tag_rx = "R7";
    step(0, 0, 0, 1);
    idle(12, 12);
    idle(5, 5);
    check(link_status, 1'b1, "R7", "status after early beat");
    tag_rx = "R9";
    idle(15, 15);
    check(link_status, 1'b0, "R9", "status after armed beat pair");

    tag_rx = "R8";
    idle(TFAIL + 10, 0);
    check(link_status, 1'b1, "R8", "status after silence");
    tag_rx = "R9";
    idle(1, 1);
    idle(14, 0);
    check(link_status, 1'b1, "R9", "single beat must not recover");
    idle(1, 1);
    check(link_status, 1'b0, "R9", "second spaced beat recovers");

    tag_rx = "R8";
    for (int i = 0; i < 3; i++) idle(TMAX + 5, TMAX + 5);
    idle(TFAIL, 0);
    tag_rx = "R10";
    for (int i = 0; i < 4 * BLINK + 3; i++) step(0, 0, 0, 1);
    idle(3, 0);

    tag_tx = "R1"; tag_rx = "R6";
    begin
      int fr = 0, nb = 15, db = 0;
      for (int i = 0; i < 4000; i++) begin
        bit en, tg, bt, dv;
        if (fr == 0 && $urandom_range(0, 59) == 0) fr = $urandom_range(5, 20);
        en = (fr > 0) ? 1'b1 : ($urandom_range(0, 3) == 0);
        tg = (fr > 0) ? ($urandom_range(0, 2) != 0) : ($urandom_range(0, 5) == 0);
        if (fr > 0) fr--;
        bt = (nb == 0);
        if (nb == 0) nb = ($urandom_range(0, 9) == 0) ? $urandom_range(TMAX + 1, TFAIL + 10)
                                                       : $urandom_range(TMIN - 4, TMAX + 3);
        else nb--;
        if (db == 0 && $urandom_range(0, 299) == 0) db = $urandom_range(5, 25);
        dv = (db > 0);
        if (db > 0) db--;
        step(en, tg, bt, dv);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog cycle=%0d actual=hung expected=finished", n);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule